// File: doc/BRIEF.md
# SD Card Command Path Engine

This block issues one command on the single-wire command line of an SD or MMC card and, when asked, collects the card's reply. The host supplies a 6-bit command index, a 32-bit argument and a 2-bit response selector, then pulses `start`. The block serialises a 48-bit command frame with its own CRC7. It then either finishes at once or releases the line and waits for the card to answer with a 48-bit or 136-bit response.

Everything advances on `ck_stb`, a one-cycle strobe in the system clock domain that marks one card clock period. On each strobe the block presents the next outgoing bit and samples `cmd_in`. Completion is signalled by exactly one single-cycle flag: sent, response good, response CRC error, or timeout. `busy` covers the whole operation. The response index and four response words are held in registers until the next response arrives.

Top module: `sdc_cmd_path`

## Requirements
- R1: During and after reset, `busy`, `cmd_oe` and all four completion flags are 0, `cmd_out` is 1, and `rsp_idx` and all response words are 0.
- R2: After an accepted `start`, the block drives a 48-bit frame MSB first with `cmd_oe` high throughout. The frame is: a 0, a 1, the 6-bit index, the 32-bit argument, the CRC7, and a final 1. The line moves on by exactly one bit per `ck_stb` and holds its value between strobes.
- R3: The CRC7 covers the first 40 frame bits, starting from zero, with polynomial x^7 + x^3 + 1. Index 0 with argument 0 therefore gives the frame 0x400000000095, and index 17 with argument 0 gives 0x510000000055.
- R4: With response selector 00 or 10, `cmd_sent` pulses for one cycle in the cycle right after the strobe that ends the last frame bit. `busy` falls in that same cycle.
- R5: With selector 01 (short) or 11 (long), `cmd_oe` is 0 right after the last frame bit, and `busy` stays high while the block samples `cmd_in` for a 0 start bit.
- R6: If 64 consecutive samples after the frame are all 1, `rsp_tmo` pulses and `busy` falls. A start bit found on the 64th sample is still accepted.
- R7: A short response is 48 bits: 0, a transmission bit, a 6-bit index, a 32-bit payload, CRC7 and an end bit. The CRC covers the first 40 bits. If it matches, `rsp_ok` pulses. `rsp_idx` takes the index field, `rsp_w0` takes the payload, and `rsp_w1`..`rsp_w3` become 0.
- R8: A long response is 136 bits: 0, a transmission bit, 6 header bits, 127 data bits and an end bit. The CRC covers the first 120 data bits and must equal the next 7. `rsp_idx` takes the header bits. The data bits followed by a 0 form 128 bits, split MSB first into `rsp_w0`..`rsp_w3`.
- R9: On a CRC mismatch, `rsp_crc_err` pulses instead of `rsp_ok`. The received index and words are captured all the same.
- R10: `busy` rises in the cycle after an accepted `start` and falls in the cycle its single completion flag pulses. Each command gives exactly one flag.
- R11: A `start` seen while `busy` is high is ignored. The frame in progress and its latched response selector do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_stb | input | 1 | One-cycle strobe per card clock period |
| start | input | 1 | Begin a command when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | 00/10 none, 01 short, 11 long |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Command in progress |
| cmd_sent | output | 1 | Pulse: command without response finished |
| rsp_ok | output | 1 | Pulse: response received, CRC good |
| rsp_crc_err | output | 1 | Pulse: response received, CRC bad |
| rsp_tmo | output | 1 | Pulse: no response start bit in time |
| rsp_idx | output | 6 | Captured response index/header field |
| rsp_w0 | output | 32 | Response word 0 (short payload or long bits 127:96) |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 |

## Verification
The bench targets the timeout boundary by placing the start bit on sample 63, 64 and 65. A design with an off-by-one counter would either time out a valid reply or hang one sample too long. It flips a single received CRC bit in both response lengths, which catches an engine that checks the wrong window or one that skips the long-response header. It checks the known frames for indices 0 and 17 against the CRC polynomial, and it uses selector 10 to catch decoding that treats any nonzero selector as a response request. It also pulses `start` in the middle of a frame with different fields; a design that re-latches them would corrupt the remaining bits or change the response handling.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IDX_W   = 6;
  localparam int ARG_W   = 32;
  localparam int CRC_W   = 7;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RECV = 2'd3
  } cp_state_e;

  // one serial step of CRC7, generator x^7 + x^3 + 1
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc7_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdc_cmd_ser.sv
module sdc_cmd_ser
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             line_bit,
  output logic             last
);
  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] HDR_C  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CRCE_C = CNT_W'(HDR_W + CRC_W);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_W - 1);

  logic [HDR_W-1:0] data_q, data_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] crc_pos;
  logic [CRC_W-1:0] crc_val, crc_shl;
  logic             in_hdr, in_crc;

  assign in_hdr  = cnt_q < HDR_C;
  assign in_crc  = !in_hdr && (cnt_q < CRCE_C);
  assign crc_pos = cnt_q - HDR_C;
  assign crc_shl = crc_val << crc_pos;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (load) begin
      data_d = {2'b01, idx, arg};
      cnt_d  = '0;
    end else if (step) begin
      data_d = data_q << 1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  sdc_crc7 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (load),
    .en   (step && in_hdr),
    .din  (data_q[HDR_W-1]),
    .crc  (crc_val)
  );

  always_comb begin
    if (in_hdr)      line_bit = data_q[HDR_W-1];
    else if (in_crc) line_bit = crc_shl[CRC_W-1];
    else             line_bit = 1'b1;
  end

  assign last = (cnt_q == LAST_C);
endmodule

// File: rtl/sdc_rsp_des.sv
module sdc_rsp_des
  import sdc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       step,
  input  logic                       din,
  input  logic                       long_mode,
  output logic                       at_last,
  output logic                       crc_good,
  output logic [IDX_W-1:0]           idx,
  output logic [WORD_W*N_WORDS-1:0]  body
);
  localparam int FIELD_W  = WORD_W * N_WORDS;
  localparam int HDR_END  = 2 + IDX_W;
  localparam int S_BODY_H = HDR_END + WORD_W - 1;
  localparam int L_BODY_H = HDR_END + FIELD_W - 2;
  localparam int S_LAST   = S_BODY_H + CRC_W + 1;
  localparam int L_LAST   = L_BODY_H + 1;
  localparam int CNT_W    = $clog2(L_LAST + 1);

  localparam logic [CNT_W-1:0] IDX_LO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] BODY_LO = CNT_W'(HDR_END);
  localparam logic [CNT_W-1:0] SBODY_H = CNT_W'(S_BODY_H);
  localparam logic [CNT_W-1:0] LBODY_H = CNT_W'(L_BODY_H);
  localparam logic [CNT_W-1:0] SCRC_H  = CNT_W'(S_BODY_H);
  localparam logic [CNT_W-1:0] LCRC_H  = CNT_W'(L_BODY_H - CRC_W);
  localparam logic [CNT_W-1:0] SLAST   = CNT_W'(S_LAST);
  localparam logic [CNT_W-1:0] LLAST   = CNT_W'(L_LAST);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FIELD_W-1:0] body_q, body_d;
  logic [CRC_W-1:0]   rcrc_q, rcrc_d;
  logic [CRC_W-1:0]   crc_val;
  logic [CNT_W-1:0]   body_hi, crc_lo, crc_hi, last_pos;
  logic               w_idx, w_body, w_crc, w_rcrc;

  assign body_hi  = long_mode ? LBODY_H : SBODY_H;
  assign crc_lo   = long_mode ? BODY_LO : ONE_C;
  assign crc_hi   = long_mode ? LCRC_H  : SCRC_H;
  assign last_pos = long_mode ? LLAST   : SLAST;

  assign w_idx  = (cnt_q >= IDX_LO) && (cnt_q < BODY_LO);
  assign w_body = (cnt_q >= BODY_LO) && (cnt_q <= body_hi);
  assign w_crc  = (cnt_q >= crc_lo) && (cnt_q <= crc_hi);
  assign w_rcrc = (cnt_q > crc_hi) && (cnt_q < last_pos);

  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    body_d = body_q;
    rcrc_d = rcrc_q;
    if (clr) begin
      cnt_d  = ONE_C;
      idx_d  = '0;
      body_d = '0;
      rcrc_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (w_idx)  idx_d  = {idx_q[IDX_W-2:0], din};
      if (w_body) body_d = {body_q[FIELD_W-2:0], din};
      if (w_rcrc) rcrc_d = {rcrc_q[CRC_W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      body_q <= '0;
      rcrc_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      body_q <= body_d;
      rcrc_q <= rcrc_d;
    end
  end

  sdc_crc7 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .en   (step && !clr && w_crc),
    .din  (din),
    .crc  (crc_val)
  );

  assign at_last  = (cnt_q == last_pos);
  assign crc_good = (crc_val == rcrc_q);
  assign idx      = idx_q;
  assign body     = body_q;
endmodule

// File: rtl/sdc_cmd_path.sv
module sdc_cmd_path
  import sdc_pkg::*;
#(
  parameter int TMO_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ck_stb,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [1:0]        rsp_type,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              cmd_sent,
  output logic              rsp_ok,
  output logic              rsp_crc_err,
  output logic              rsp_tmo,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [WORD_W-1:0] rsp_w0,
  output logic [WORD_W-1:0] rsp_w1,
  output logic [WORD_W-1:0] rsp_w2,
  output logic [WORD_W-1:0] rsp_w3
);
  localparam int FIELD_W = WORD_W * N_WORDS;
  localparam int TMO_W   = $clog2(TMO_LEN);
  localparam logic [TMO_W-1:0] TMO_END = TMO_W'(TMO_LEN - 1);

  cp_state_e state_q, state_d;
  logic want_q, want_d, long_q, long_d;
  logic [TMO_W-1:0] tmo_cnt_q, tmo_cnt_d;
  logic sent_q, sent_d, ok_q, ok_d, err_q, err_d, tmo_q, tmo_d;
  logic ser_load, ser_step, ser_bit, ser_last;
  logic des_clr, des_step, des_last, des_crc_good, cap;
  logic [IDX_W-1:0]   des_idx;
  logic [FIELD_W-1:0] des_body, long_field;
  logic [IDX_W-1:0]   ridx_q;
  logic [N_WORDS-1:0][WORD_W-1:0] words_q, words_nx;

  always_comb begin
    state_d   = state_q;
    want_d    = want_q;
    long_d    = long_q;
    tmo_cnt_d = tmo_cnt_q;
    sent_d = 1'b0; ok_d = 1'b0; err_d = 1'b0; tmo_d = 1'b0;
    ser_load = 1'b0; ser_step = 1'b0;
    des_clr  = 1'b0; des_step = 1'b0; cap = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SEND;
          ser_load = 1'b1;
          want_d   = rsp_type[0];
          long_d   = &rsp_type;
        end
      end
      ST_SEND: begin
        if (ck_stb) begin
          ser_step = 1'b1;
          if (ser_last) begin
            if (want_q) begin
              state_d   = ST_WAIT;
              tmo_cnt_d = '0;
            end else begin
              state_d = ST_IDLE;
              sent_d  = 1'b1;
            end
          end
        end
      end
      ST_WAIT: begin
        if (ck_stb) begin
          if (!cmd_in) begin
            state_d = ST_RECV;
            des_clr = 1'b1;
          end else if (tmo_cnt_q == TMO_END) begin
            state_d = ST_IDLE;
            tmo_d   = 1'b1;
          end else begin
            tmo_cnt_d = tmo_cnt_q + 1'b1;
          end
        end
      end
      ST_RECV: begin
        if (ck_stb) begin
          des_step = 1'b1;
          if (des_last) begin
            state_d = ST_IDLE;
            cap     = 1'b1;
            ok_d    = des_crc_good;
            err_d   = !des_crc_good;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      want_q    <= 1'b0;
      long_q    <= 1'b0;
      tmo_cnt_q <= '0;
      sent_q    <= 1'b0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      want_q    <= want_d;
      long_q    <= long_d;
      tmo_cnt_q <= tmo_cnt_d;
      sent_q    <= sent_d;
      ok_q      <= ok_d;
      err_q     <= err_d;
      tmo_q     <= tmo_d;
    end
  end

  sdc_cmd_ser u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ser_load),
    .step    (ser_step),
    .idx     (cmd_idx),
    .arg     (cmd_arg),
    .line_bit(ser_bit),
    .last    (ser_last)
  );

  sdc_rsp_des u_des (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (des_clr),
    .step     (des_step),
    .din      (cmd_in),
    .long_mode(long_q),
    .at_last  (des_last),
    .crc_good (des_crc_good),
    .idx      (des_idx),
    .body     (des_body)
  );

  // long responses carry 127 data bits; a zero fills the last position
  assign long_field = {des_body[FIELD_W-2:0], 1'b0};

  for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
    if (gi == 0) begin : g_first
      assign words_nx[gi] = long_q ? long_field[FIELD_W-1 -: WORD_W] : des_body[WORD_W-1:0];
    end else begin : g_rest
      assign words_nx[gi] = long_q ? long_field[FIELD_W-1-gi*WORD_W -: WORD_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q  <= '0;
      words_q <= '0;
    end else if (cap) begin
      ridx_q  <= des_idx;
      words_q <= words_nx;
    end
  end

  assign cmd_oe      = (state_q == ST_SEND);
  assign cmd_out     = cmd_oe ? ser_bit : 1'b1;
  assign busy        = (state_q != ST_IDLE);
  assign cmd_sent    = sent_q;
  assign rsp_ok      = ok_q;
  assign rsp_crc_err = err_q;
  assign rsp_tmo     = tmo_q;
  assign rsp_idx     = ridx_q;
  assign rsp_w0      = words_q[0];
  assign rsp_w1      = words_q[1];
  assign rsp_w2      = words_q[2];
  assign rsp_w3      = words_q[3];
endmodule

// File: rtl/sdc_cmd_path_chk.sv
module sdc_cmd_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ck_stb,
  input logic       start,
  input logic       cmd_out,
  input logic       cmd_oe,
  input logic       busy,
  input logic       cmd_sent,
  input logic       rsp_ok,
  input logic       rsp_crc_err,
  input logic       rsp_tmo,
  input logic [5:0] rsp_idx
);
  AST_LINE_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out); // R1
  AST_LINE_HOLDS_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ck_stb) |=> ($stable(cmd_out) && $stable(cmd_oe))); // R2
  AST_SENT_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |-> $past(cmd_oe)); // R4
  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy); // R5
  AST_TMO_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tmo |-> $past(busy && !cmd_oe)); // R6
  AST_RSP_AFTER_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok || rsp_crc_err) |-> $past(busy && !cmd_oe)); // R7
  AST_IDX_ONLY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_idx) |-> (rsp_ok || rsp_crc_err)); // R9
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_sent, rsp_ok, rsp_crc_err, rsp_tmo}) <= 1); // R10
  AST_FLAG_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sent || rsp_ok || rsp_crc_err || rsp_tmo) |-> (!busy && $past(busy))); // R10
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
endmodule

bind sdc_cmd_path sdc_cmd_path_chk u_chk (.*);

// File: tb/tb_sdc_cmd_path.sv
module tb_sdc_cmd_path;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ck_stb, start, cmd_in;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic [1:0]  rsp_type;
  logic cmd_out, cmd_oe, busy, cmd_sent, rsp_ok, rsp_crc_err, rsp_tmo;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;

  sdc_cmd_path dut (.*);

  int n_chk = 0, n_bad = 0, n_flag = 0;
  logic [47:0] last_frame;

  always @(posedge clk) begin
    #1;
    n_flag = n_flag + int'(cmd_sent) + int'(rsp_ok) + int'(rsp_crc_err) + int'(rsp_tmo);
  end

  task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] tb_crc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c;
    c = '0;
    for (int k = hi; k >= lo; k--) begin
      logic fb;
      fb = c[6] ^ v[k];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] i, input logic [31:0] a);
    logic [135:0] h;
    h = '0;
    h[39:0] = {2'b01, i, a};
    return {h[39:0], tb_crc(h, 39, 0), 1'b1};
  endfunction

  task automatic tick();
    repeat (2) @(negedge clk);
    ck_stb = 1'b1;
    @(negedge clk);
    ck_stb = 1'b0;
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input int dly, input bit corrupt, input bit poke);
    logic [47:0]  got, ef;
    logic [135:0] rv;
    logic [127:0] fld;
    logic [5:0]   ridx;
    logic [31:0]  pay;
    int  n, f0;
    bit  oe_ok;
    ef = exp_frame(idx, arg);
    rv = '0;
    ridx = 6'($urandom);
    pay  = $urandom;
    if (rt == 2'b11) begin
      fld = {$urandom, $urandom, $urandom, $urandom};
      rv[135:128] = {2'b00, 6'h3F};
      rv[127:1]   = fld[127:1];
      rv[7:1]     = tb_crc(rv, 127, 8);
      rv[0]       = 1'b1;
      n = 136;
    end else begin
      rv[47:8] = {2'b00, ridx, pay};
      rv[7:1]  = tb_crc(rv, 47, 8);
      rv[0]    = 1'b1;
      n = 48;
    end
    if (corrupt) rv[1] = ~rv[1];
    f0 = n_flag;
    oe_ok = 1'b1;
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; rsp_type = rt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", 136'(busy), 136'(1));
    for (int i = 0; i < 48; i++) begin
      if (cmd_oe !== 1'b1) oe_ok = 1'b0;
      got[47-i] = cmd_out;
      if (poke && i == 10) begin
        cmd_idx = ~idx; cmd_arg = ~arg; rsp_type = ~rt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      tick();
    end
    last_frame = got;
    chk("R2 drive enable during frame", 136'(oe_ok), 136'(1));
    chk(poke ? "R11 frame kept on busy start" : "R2 R3 frame", 136'(got), 136'(ef));
    if (!rt[0]) begin
      chk("R4 sent pulse", 136'({cmd_sent, rsp_ok, rsp_crc_err, rsp_tmo}), 136'(4'b1000));
      chk("R4 busy low", 136'(busy), 136'(0));
    end else begin
      chk("R5 released and waiting", 136'({cmd_oe, busy}), 136'(2'b01));
      for (int i = 0; i < ((dly > 64) ? 64 : dly); i++) begin
        cmd_in = 1'b1;
        tick();
      end
      if (dly >= 64) begin
        chk("R6 timeout", 136'({cmd_sent, rsp_ok, rsp_crc_err, rsp_tmo, busy}), 136'(5'b00010));
      end else begin
        for (int j = n - 1; j >= 0; j--) begin
          cmd_in = rv[j];
          tick();
        end
        cmd_in = 1'b1;
        if (corrupt)
          chk("R9 crc error flag", 136'({rsp_ok, rsp_crc_err, busy}), 136'(3'b010));
        else
          chk(n == 136 ? "R8 long ok flag" : "R7 short ok flag",
              136'({rsp_ok, rsp_crc_err, busy}), 136'(3'b100));
        if (n == 136) begin
          chk("R8 header idx", 136'(rsp_idx), 136'(6'h3F));
          chk("R8 words", {8'h0, rsp_w0, rsp_w1, rsp_w2, rsp_w3}, {8'h0, rv[127:1], 1'b0});
        end else begin
          chk("R7 idx", 136'(rsp_idx), 136'(ridx));
          chk("R7 words", {8'h0, rsp_w0, rsp_w1, rsp_w2, rsp_w3}, {8'h0, pay, 96'h0});
        end
      end
    end
    repeat (3) @(negedge clk);
    chk("R10 one flag per command", 136'(n_flag - f0), 136'(1));
    chk("R10 idle after command", 136'(busy), 136'(0));
  endtask

  bit done = 1'b0;
  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ck_stb = 1'b0; start = 1'b0; cmd_in = 1'b1;
    cmd_idx = '0; cmd_arg = '0; rsp_type = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 136'({busy, cmd_oe, cmd_out, cmd_sent, rsp_ok, rsp_crc_err, rsp_tmo}),
        136'(7'b0010000));
    chk("R1 reset response", {8'h0, rsp_idx, rsp_w0, rsp_w1, rsp_w2, rsp_w3}, 136'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cmd(6'd0, 32'h0, 2'b00, 0, 1'b0, 1'b0);
    chk("R3 known frame idx0", 136'(last_frame), 136'(48'h400000000095));
    run_cmd(6'd17, 32'h0, 2'b10, 0, 1'b0, 1'b0);
    chk("R3 known frame idx17", 136'(last_frame), 136'(48'h510000000055));
    run_cmd(6'd8, 32'h1AA, 2'b01, 2, 1'b0, 1'b0);
    run_cmd(6'd2, 32'h0, 2'b11, 5, 1'b0, 1'b0);
    run_cmd(6'd13, 32'hDEAD0000, 2'b01, 63, 1'b0, 1'b0);
    run_cmd(6'd13, 32'h12345678, 2'b01, 64, 1'b0, 1'b0);
    run_cmd(6'd9, 32'h0, 2'b11, 65, 1'b0, 1'b0);
    run_cmd(6'd55, 32'hFFFFFFFF, 2'b01, 0, 1'b1, 1'b0);
    run_cmd(6'd10, 32'hA5A5A5A5, 2'b11, 1, 1'b1, 1'b0);
    run_cmd(6'd3, 32'h00FF00FF, 2'b01, 3, 1'b0, 1'b1);
    run_cmd(6'd6, 32'h0F0F0F0F, 2'b00, 0, 1'b0, 1'b1);

    for (int r = 0; r < 24; r++) begin
      logic [1:0] rt;
      int d;
      rt = 2'($urandom);
      d  = ($urandom % 8 == 0) ? 60 + int'($urandom % 8) : int'($urandom % 20);
      run_cmd(6'($urandom), $urandom, rt, d, ($urandom % 4) == 0, 1'b0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule